// File: doc/BRIEF.md
# Two-Point ADC Linear Corrector

This block turns raw converter codes into corrected codes with a straight-line law fitted through two reference readings. For calibration the caller supplies two raw conversions: one taken while the converter input sits at one quarter of full scale, and one taken at three quarters. From these the block works out a gain held in millionths and a signed offset. A sequential divider does this over a few hundred cycles. A one-cycle done pulse marks the moment the new pair of coefficients takes effect.

In normal operation each raw sample goes through a short pipeline that multiplies it by the gain, divides by one million, adds the offset, and saturates the result to the converter's code range. Samples are held off with a ready signal while a calibration is running. After reset the coefficients give an identity mapping, so the block can sit in the sample path before any calibration has been done. The converter resolution is a parameter; 10 and 12 bits are the intended settings.

Top module: `adc_lin_corrector`

## Requirements
- R1: After reset, coef_scale reads 1000000, coef_bias reads 0, cal_busy and out_valid are low and in_ready is high, so samples leave the block equal to their low RES_BITS bits.
- R2: Only the low RES_BITS bits of in_raw, cal_raw_lo and cal_raw_hi are used; higher bits have no effect on any result.
- R3: A sample accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid exactly LAT = 2 + SPLIT_STAGE edges later (3 by default). Its value is floor(scale*raw/1000000) + bias, using the coefficients in force when it was accepted.
- R4: A successful calibration sets coef_scale to floor(2^(RES_BITS-1) * 1000000 / (hi - lo)), where lo and hi are the masked quarter-scale and three-quarter-scale readings.
- R5: A successful calibration sets coef_bias to 2^RES_BITS/4 - floor(lo * new_scale / 1000000).
- R6: A calibration request with hi not greater than lo is rejected. cal_done and cal_err pulse together on the edge after the request, and both coefficients keep their previous values.
- R7: While a calibration is running, cal_busy is high and in_ready is low. A sample held on in_valid during that time is not accepted. It is accepted on the edge after cal_done, and it is corrected with the new coefficients.
- R8: The coefficient outputs change only on the edge that raises cal_done. cal_done is high for exactly one cycle per request.
- R9: The corrected value is saturated: a result below 0 gives 0, and a result above 2^RES_BITS - 1 gives 2^RES_BITS - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Request a calibration from the two readings below |
| cal_raw_lo | input | RAW_W | Raw reading taken at one quarter of full scale |
| cal_raw_hi | input | RAW_W | Raw reading taken at three quarters of full scale |
| cal_busy | output | 1 | Calibration arithmetic in progress |
| cal_done | output | 1 | One-cycle pulse: request finished |
| cal_err | output | 1 | One-cycle pulse with cal_done: request rejected |
| coef_scale | output | SCALE_W | Gain in millionths currently applied |
| coef_bias | output | BIAS_W | Signed offset currently applied |
| in_valid | input | 1 | Raw sample present |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_raw | input | RAW_W | Raw sample |
| out_valid | output | 1 | Corrected sample present for one cycle |
| out_data | output | RES_BITS | Corrected, saturated sample |

## Verification
Results from the sample path are due exactly three edges after the edge that accepts a sample. The bench records the negedge index at which each accepted sample is seen and the value expected from the coefficients in force then. It pops that entry when out_valid is seen and requires both the value and a distance of exactly three negedges. A rejected calibration is due on the first edge after the request, so its pulses and unchanged coefficients are sampled on the negedge just after that edge. A successful calibration takes a divider-dependent number of cycles, so the bench polls each negedge, requires in_ready low until cal_done, and then checks the coefficients on that same negedge and the absence of cal_done on the next one. Full sweeps of all 1024 codes follow each coefficient change.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

   localparam int  WIDE_W  = 64;
   localparam longint PPM_ONE = 1_000_000;

   typedef logic [WIDE_W-1:0]        wide_u_t;
   typedef logic signed [WIDE_W-1:0] wide_s_t;

   typedef enum logic [1:0] {
      CE_IDLE  = 2'd0,
      CE_SCALE = 2'd1,
      CE_BIAS  = 2'd2
   } coef_state_t;

endpackage

// File: rtl/adc_seq_div.sv
module adc_seq_div #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  dvs_q;
   logic [CW-1:0] cnt_q;

   logic [W:0]    rem_sh;
   logic          fits;
   logic [W:0]    rem_nx;

   always_comb begin
      rem_sh = {rem_q, quo_q[W-1]};
      fits   = (rem_sh >= {1'b0, dvs_q});
      rem_nx = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CW'(W);
            busy  <= 1'b1;
         end else if (busy) begin
            rem_q <= rem_nx[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quotient = quo_q;

endmodule

// File: rtl/adc_coef_engine.sv
module adc_coef_engine
   import adc_cal_pkg::*;
#(
   parameter int RES_BITS = 10,
   parameter int RAW_W    = 16,
   parameter int SCALE_W  = 32,
   parameter int BIAS_W   = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cal_start,
   input  logic [RAW_W-1:0]          raw_lo,
   input  logic [RAW_W-1:0]          raw_hi,
   output logic                      busy,
   output logic                      done,
   output logic                      err,
   output logic [SCALE_W-1:0]        scale,
   output logic signed [BIAS_W-1:0]  bias
);
   localparam wide_u_t SPAN      = wide_u_t'(1) << (RES_BITS - 1);
   localparam wide_u_t SCALE_NUM = SPAN * wide_u_t'(PPM_ONE);
   localparam wide_s_t NOM_LO    = wide_s_t'(1) <<< (RES_BITS - 2);

   coef_state_t          state_q;
   logic [RES_BITS-1:0]  lo_m, hi_m, lo_q;
   wide_u_t              scale_tmp_q;
   logic                 ordered;

   logic                 div_start, div_busy, div_done;
   wide_u_t              div_num, div_den, div_q;

   assign lo_m    = RES_BITS'(raw_lo);
   assign hi_m    = RES_BITS'(raw_hi);
   assign ordered = (hi_m > lo_m);

   always_comb begin
      div_start = ((state_q == CE_IDLE) && cal_start && ordered) ||
                  ((state_q == CE_SCALE) && div_done);
      if (state_q == CE_IDLE) begin
         div_num = SCALE_NUM;
         div_den = wide_u_t'(hi_m - lo_m);
      end else begin
         div_num = wide_u_t'(lo_q) * div_q;
         div_den = wide_u_t'(PPM_ONE);
      end
   end

   adc_seq_div #(.W(WIDE_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (div_num),
      .divisor  (div_den),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (div_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= CE_IDLE;
         lo_q        <= '0;
         scale_tmp_q <= '0;
         scale       <= SCALE_W'(PPM_ONE);
         bias        <= '0;
         done        <= 1'b0;
         err         <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state_q)
            CE_IDLE: begin
               if (cal_start) begin
                  if (ordered) begin
                     lo_q    <= lo_m;
                     state_q <= CE_SCALE;
                  end else begin
                     done <= 1'b1;
                     err  <= 1'b1;
                  end
               end
            end
            CE_SCALE: begin
               if (div_done) begin
                  scale_tmp_q <= div_q;
                  state_q     <= CE_BIAS;
               end
            end
            CE_BIAS: begin
               if (div_done) begin
                  scale   <= SCALE_W'(scale_tmp_q);
                  bias    <= BIAS_W'(NOM_LO - $signed(div_q));
                  done    <= 1'b1;
                  state_q <= CE_IDLE;
               end
            end
            default: state_q <= CE_IDLE;
         endcase
      end
   end

   assign busy = (state_q != CE_IDLE) || div_busy;

endmodule

// File: rtl/adc_sample_path.sv
module adc_sample_path
   import adc_cal_pkg::*;
#(
   parameter int RES_BITS    = 10,
   parameter int RAW_W       = 16,
   parameter int SCALE_W     = 32,
   parameter int BIAS_W      = 32,
   parameter bit SPLIT_STAGE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire,
   input  logic [RAW_W-1:0]         raw,
   input  logic [SCALE_W-1:0]       scale,
   input  logic signed [BIAS_W-1:0] bias,
   output logic                     out_valid,
   output logic [RES_BITS-1:0]      out_data
);
   localparam wide_s_t MAXV = (wide_s_t'(1) <<< RES_BITS) - wide_s_t'(1);

   logic [RES_BITS-1:0] raw_m;
   logic                v1_q;
   wide_u_t             prod_q;
   logic                v2;
   wide_u_t             quo2;
   wide_s_t             bias_x;
   wide_s_t             sum;

   assign raw_m  = RES_BITS'(raw);
   assign bias_x = {{(WIDE_W - BIAS_W){bias[BIAS_W-1]}}, bias};

   // stage 1: gain multiply
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q   <= 1'b0;
         prod_q <= '0;
      end else begin
         v1_q   <= fire;
         prod_q <= wide_u_t'(scale) * wide_u_t'(raw_m);
      end
   end

   // stage 2: divide by one million, registered or folded into stage 3
   generate
      if (SPLIT_STAGE) begin : g_split
         logic    v2_q;
         wide_u_t quo_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v2_q  <= 1'b0;
               quo_q <= '0;
            end else begin
               v2_q  <= v1_q;
               quo_q <= prod_q / wide_u_t'(PPM_ONE);
            end
         end
         assign v2   = v2_q;
         assign quo2 = quo_q;
      end else begin : g_fold
         assign v2   = v1_q;
         assign quo2 = prod_q / wide_u_t'(PPM_ONE);
      end
   endgenerate

   // stage 3: offset and saturation
   assign sum = $signed(quo2) + bias_x;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= v2;
         if (sum < 0)
            out_data <= '0;
         else if (sum > MAXV)
            out_data <= MAXV[RES_BITS-1:0];
         else
            out_data <= sum[RES_BITS-1:0];
      end
   end

endmodule

// File: rtl/adc_lin_corrector.sv
module adc_lin_corrector #(
   parameter int RES_BITS    = 10,
   parameter int RAW_W       = 16,
   parameter int SCALE_W     = 32,
   parameter int BIAS_W      = 32,
   parameter bit SPLIT_STAGE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal_start,
   input  logic [RAW_W-1:0]         cal_raw_lo,
   input  logic [RAW_W-1:0]         cal_raw_hi,
   output logic                     cal_busy,
   output logic                     cal_done,
   output logic                     cal_err,
   output logic [SCALE_W-1:0]       coef_scale,
   output logic signed [BIAS_W-1:0] coef_bias,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [RAW_W-1:0]         in_raw,
   output logic                     out_valid,
   output logic [RES_BITS-1:0]      out_data
);
   localparam int LAT = 2 + int'(SPLIT_STAGE);

   generate
      if (RES_BITS < 4 || RES_BITS > 16) begin : g_bad_res
         $error("RES_BITS must lie in 4..16");
      end
      if (RAW_W < RES_BITS) begin : g_bad_raw
         $error("RAW_W must be at least RES_BITS");
      end
      if (SCALE_W < RES_BITS + 20 || SCALE_W > 64) begin : g_bad_scale
         $error("SCALE_W must hold 2^(RES_BITS-1) million and fit 64 bits");
      end
      if (BIAS_W < 2 * RES_BITS + 1 || BIAS_W > 64) begin : g_bad_bias
         $error("BIAS_W must be at least 2*RES_BITS+1 and at most 64");
      end
      if (LAT < 2 || LAT > 3) begin : g_bad_lat
         $error("pipeline latency out of range");
      end
   endgenerate

   logic fire;

   assign in_ready = !cal_busy;
   assign fire     = in_valid && in_ready;

   adc_coef_engine #(
      .RES_BITS (RES_BITS),
      .RAW_W    (RAW_W),
      .SCALE_W  (SCALE_W),
      .BIAS_W   (BIAS_W)
   ) u_coef (
      .clk       (clk),
      .rst_n     (rst_n),
      .cal_start (cal_start),
      .raw_lo    (cal_raw_lo),
      .raw_hi    (cal_raw_hi),
      .busy      (cal_busy),
      .done      (cal_done),
      .err       (cal_err),
      .scale     (coef_scale),
      .bias      (coef_bias)
   );

   adc_sample_path #(
      .RES_BITS    (RES_BITS),
      .RAW_W       (RAW_W),
      .SCALE_W     (SCALE_W),
      .BIAS_W      (BIAS_W),
      .SPLIT_STAGE (SPLIT_STAGE)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .raw       (in_raw),
      .scale     (coef_scale),
      .bias      (coef_bias),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: rtl/adc_lin_corrector_chk.sv
module adc_lin_corrector_chk #(
   parameter int RES_BITS = 10,
   parameter int RAW_W    = 16,
   parameter int SCALE_W  = 32,
   parameter int BIAS_W   = 32,
   parameter int LAT      = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cal_start,
   input logic                     cal_busy,
   input logic                     cal_done,
   input logic                     cal_err,
   input logic [SCALE_W-1:0]       coef_scale,
   input logic signed [BIAS_W-1:0] coef_bias,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     out_valid
);

   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> !in_ready);

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> ##LAT out_valid);

   assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cal_err |-> (cal_done && $stable(coef_scale) && $stable(coef_bias)));

   assert_coef_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(coef_scale) || !$stable(coef_bias)) |-> cal_done);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   assert_scale_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !cal_err) |-> (coef_scale != '0));

endmodule

bind adc_lin_corrector adc_lin_corrector_chk #(
   .RES_BITS (RES_BITS),
   .RAW_W    (RAW_W),
   .SCALE_W  (SCALE_W),
   .BIAS_W   (BIAS_W),
   .LAT      (LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cal_start  (cal_start),
   .cal_busy   (cal_busy),
   .cal_done   (cal_done),
   .cal_err    (cal_err),
   .coef_scale (coef_scale),
   .coef_bias  (coef_bias),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid)
);

// File: tb/adc_lin_corrector_tb.sv
`timescale 1ns/1ps
module adc_lin_corrector_tb;
   localparam int RES  = 10;
   localparam int RAWW = 16;
   localparam int LAT  = 3;
   localparam longint MAXC = (longint'(1) << RES) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic               rst_n;
   logic               cal_start;
   logic [RAWW-1:0]    cal_raw_lo, cal_raw_hi;
   logic               cal_busy, cal_done, cal_err;
   logic [31:0]        coef_scale;
   logic signed [31:0] coef_bias;
   logic               in_valid, in_ready;
   logic [RAWW-1:0]    in_raw;
   logic               out_valid;
   logic [RES-1:0]     out_data;

   adc_lin_corrector u_dut (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
      .cal_raw_lo(cal_raw_lo), .cal_raw_hi(cal_raw_hi),
      .cal_busy(cal_busy), .cal_done(cal_done), .cal_err(cal_err),
      .coef_scale(coef_scale), .coef_bias(coef_bias),
      .in_valid(in_valid), .in_ready(in_ready), .in_raw(in_raw),
      .out_valid(out_valid), .out_data(out_data)
   );

   int     n_chk = 0;
   int     n_err = 0;
   bit     finished = 1'b0;
   string  cur_req = "R3";
   longint exp_scale = 1000000;
   longint exp_bias  = 0;
   longint pend_scale = 1000000;
   longint pend_bias  = 0;
   longint q_val[$];
   int     q_cyc[$];
   int     mcyc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint corrected(input longint raw);
      longint t;
      t = (exp_scale * raw) / 1000000 + exp_bias;
      if (t < 0) t = 0;
      if (t > MAXC) t = MAXC;
      return t;
   endfunction

   // monitor: coefficient tracking, expected queue and latency
   initial begin
      forever begin
         @(negedge clk);
         mcyc++;
         if (rst_n) begin
            if (cal_done && !cal_err) begin
               exp_scale = pend_scale;
               exp_bias  = pend_bias;
            end
            if (out_valid) begin
               if (q_val.size() == 0) begin
                  chk(1'b0, cur_req, longint'(out_data), -1);
               end else begin
                  longint ev;
                  int     ec;
                  ev = q_val.pop_front();
                  ec = q_cyc.pop_front();
                  chk(longint'(out_data) == ev, cur_req, longint'(out_data), ev);
                  chk((mcyc - ec) == LAT, "R3 latency", longint'(mcyc - ec), LAT);
               end
            end
            if (in_valid && in_ready) begin
               q_val.push_back(corrected(longint'(in_raw[RES-1:0])));
               q_cyc.push_back(mcyc);
            end
         end
      end
   end

   task automatic sweep(input string req);
      cur_req = req;
      for (int r = 0; r <= int'(MAXC); r++) begin
         logic [RAWW-1:0] v;
         @(posedge clk); #1;
         v = RAWW'(r);
         v[RAWW-1:RES] = (RAWW-RES)'(r * 13 + 5);
         in_valid = 1'b1;
         in_raw   = v;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk);
      chk(q_val.size() == 0, {req, " drained"}, q_val.size(), 0);
   endtask

   task automatic cal_run(input logic [RAWW-1:0] lo_in, input logic [RAWW-1:0] hi_in,
                          input bit stall);
      longint lo, hi, old_s, old_b;
      int n;
      lo = longint'(lo_in[RES-1:0]);
      hi = longint'(hi_in[RES-1:0]);
      old_s = exp_scale;
      old_b = exp_bias;
      if (hi > lo) begin
         pend_scale = ((longint'(1) << (RES - 1)) * 1000000) / (hi - lo);
         pend_bias  = ((longint'(1) << RES) / 4) - (lo * pend_scale) / 1000000;
      end
      @(posedge clk); #1;
      cal_start  = 1'b1;
      cal_raw_lo = lo_in;
      cal_raw_hi = hi_in;
      if (stall) begin
         in_valid = 1'b1;
         in_raw   = RAWW'(77);
         cur_req  = "R7";
      end
      @(posedge clk); #1;
      cal_start = 1'b0;
      @(negedge clk);
      if (hi <= lo) begin
         chk(cal_done && cal_err, "R6 reject pulse", {cal_done, cal_err}, 3);
         chk(longint'(coef_scale) == old_s, "R6 scale kept", longint'(coef_scale), old_s);
         chk(longint'(coef_bias) == old_b, "R6 bias kept", longint'(coef_bias), old_b);
         @(negedge clk);
         chk(!cal_done, "R8 single pulse", cal_done, 0);
      end else begin
         chk(cal_busy && !in_ready, "R7 busy stalls", {cal_busy, in_ready}, 2);
         n = 0;
         while (!cal_done && n < 2000) begin
            @(negedge clk);
            n++;
            if (!cal_done)
               chk(!in_ready, "R7 ready low", in_ready, 0);
         end
         chk(cal_done && !cal_err, "R8 done seen", {cal_done, cal_err}, 2);
         chk(longint'(coef_scale) == pend_scale, "R4 scale", longint'(coef_scale), pend_scale);
         chk(longint'(coef_bias) == pend_bias, "R5 bias", longint'(coef_bias), pend_bias);
         @(posedge clk); #1;
         in_valid = 1'b0;
         @(negedge clk);
         chk(!cal_done, "R8 single pulse", cal_done, 0);
         repeat (LAT + 1) @(negedge clk);
         chk(q_val.size() == 0, "R7 held sample delivered", q_val.size(), 0);
      end
   endtask

   initial begin
      rst_n = 1'b0; cal_start = 1'b0; cal_raw_lo = '0; cal_raw_hi = '0;
      in_valid = 1'b0; in_raw = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(longint'(coef_scale) == 1000000, "R1 reset scale", longint'(coef_scale), 1000000);
      chk(longint'(coef_bias) == 0, "R1 reset bias", longint'(coef_bias), 0);
      chk(!out_valid && !cal_busy && in_ready, "R1 reset flags",
          {out_valid, cal_busy, in_ready}, 1);

      sweep("R2");                                 // identity with junk upper bits
      cal_run(16'd300, 16'd700, 1'b0);             // bias -128, gain 1.28
      sweep("R9");
      cal_run(16'd500, 16'd500, 1'b0);             // equal readings rejected
      cal_run(16'd700, 16'd300, 1'b0);             // reversed readings rejected
      sweep("R6");
      cal_run(16'hFC00 | 16'd200, 16'h8000 | 16'd900, 1'b1);  // masked inputs, stalled sample
      sweep("R3");
      cal_run(16'd0, 16'd1, 1'b0);                 // largest gain
      sweep("R9");
      cal_run(16'd0, 16'd1023, 1'b0);              // widest spread
      sweep("R3");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule